// File: doc/BRIEF.md
# Mode-banked register file

This block is the integer register file of a small 32-bit RISC core. Software sees sixteen registers, numbered 0 to 15. Registers 0 to 12 are general purpose, register 13 serves as the stack pointer, register 14 holds the subroutine return address and register 15 is the program counter. Three of the core's four processor modes own private shadow copies of some of these registers. An interrupt or privileged handler can therefore use its own stack pointer and link register, and the fast-interrupt handler can also use its own working registers, without saving the interrupted code's values first.

Two combinational read ports and one write port select registers by architectural index. The current 2-bit processor mode decides which physical copy an index reaches. When a mode has no private copy of an index, the access falls through to the shared base copy. The program counter advances by one 4-byte instruction on each enabled cycle, and a write to register 15 loads it instead of that increment. A read of register 15 returns the address of the executing instruction plus 8. This value is the fetch position of the three-stage pipeline.

Top module: `bankreg_file`

## Requirements
- R1: After a clock edge with `rst_n` low, `pc_q` is 0.
- R2: On each rising edge with `pc_step_en` high and no write to index 15, `pc_q` increases by 4, wrapping modulo 2^32. With `pc_step_en` low and no write to index 15, `pc_q` holds its value.
- R3: A write (`wr_en` high) to index 15 loads `wr_data` into `pc_q` at the next edge. The write takes priority over the increment of 4 and changes no other register.
- R4: A read of index 15 on either read port returns `pc_q + 8`.
- R5: In user mode (`mode` = 2'b00), indices 0 to 14 reach the base copies.
- R6: In fast-interrupt mode (`mode` = 2'b01), indices 8 to 14 reach seven private copies. Indices 0 to 7 reach the base copies.
- R7: In normal-interrupt mode (`mode` = 2'b10), indices 13 and 14 reach two private copies. Indices 0 to 12 reach the base copies.
- R8: In supervisor mode (`mode` = 2'b11), indices 13 and 14 reach two private copies, separate from those of R7. Indices 0 to 12 reach the base copies.
- R9: A write to indices 0 to 14 changes only the copy that the current mode selects. A copy owned by another mode reads back unchanged after a switch to that mode.
- R10: A write takes effect at the rising edge. In the write's own cycle a read of the same register returns the old value, and on the next cycle it returns the new value. The two read ports are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears the program counter |
| mode | input | 2 | Processor mode: 00 user, 01 fast interrupt, 10 normal interrupt, 11 supervisor |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Architectural index written |
| wr_data | input | 32 | Write data |
| pc_step_en | input | 1 | Advance the program counter by 4 this cycle |
| rd_a_idx | input | 4 | Index read on port A |
| rd_a_data | output | 32 | Port A read data (combinational) |
| rd_b_idx | input | 4 | Index read on port B |
| rd_b_data | output | 32 | Port B read data (combinational) |
| pc_q | output | 32 | Address of the instruction now executing |

## Verification
A slot-mapping error leaves no internal trace until that index is read in an affected mode. At that read, a read port returns another mode's value or a stale value, starting one cycle after the write that went to the wrong copy. The bench writes a distinct value to every mode and index pair, in two opposite mode orders, and then reads back every pair on both ports. Any misrouted or leaked write therefore shows at the next read sweep. A program-counter fault shows on `pc_q` at the very next edge, and in the same cycle it also shows in reads of index 15.

// File: rtl/bankreg_pkg.sv
// Shared constants and types for the mode-banked register file.
// Assumes a 16-entry architectural view with index 15 as the program counter.
package bankreg_pkg;

    localparam int IDX_W    = 4;
    localparam int NUM_ARCH = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IDX_PC  = 4'd15;
    localparam logic [IDX_W-1:0] FAST_LO = 4'd8;
    localparam logic [IDX_W-1:0] PAIR_LO = 4'd13;

    // Physical slot layout: base copies first, then each shadow set.
    localparam int BASE_CNT  = NUM_ARCH - 1;
    localparam int FAST_CNT  = int'(IDX_PC) - int'(FAST_LO);
    localparam int PAIR_CNT  = int'(IDX_PC) - int'(PAIR_LO);
    localparam int FAST_BASE = BASE_CNT;
    localparam int IRQ_BASE  = FAST_BASE + FAST_CNT;
    localparam int SVC_BASE  = IRQ_BASE + PAIR_CNT;
    localparam int SLOT_CNT  = SVC_BASE + PAIR_CNT;
    localparam int SLOT_W    = $clog2(SLOT_CNT);

    typedef enum logic [1:0] {
        MODE_USR  = 2'b00,
        MODE_FAST = 2'b01,
        MODE_IRQ  = 2'b10,
        MODE_SVC  = 2'b11
    } cpu_mode_e;

endpackage

// File: rtl/bankreg_map.sv
// Translates an architectural index and processor mode to a physical slot.
// Assumes index 15 is never used for storage; its result is ignored by the caller.
module bankreg_map
    import bankreg_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [SLOT_W-1:0] slot
);

    logic [SLOT_W-1:0] idx_s;
    logic              fast_hit;
    logic              pair_hit;

    // Pick the shadow slot when the mode owns a private copy, else the base slot.
    always_comb begin
        idx_s    = SLOT_W'(idx);
        fast_hit = (idx >= FAST_LO) && (idx != IDX_PC);
        pair_hit = (idx >= PAIR_LO) && (idx != IDX_PC);
        slot     = idx_s;
        case (cpu_mode_e'(mode))
            MODE_FAST: if (fast_hit) slot = idx_s - SLOT_W'(FAST_LO) + SLOT_W'(FAST_BASE);
            MODE_IRQ:  if (pair_hit) slot = idx_s - SLOT_W'(PAIR_LO) + SLOT_W'(IRQ_BASE);
            MODE_SVC:  if (pair_hit) slot = idx_s - SLOT_W'(PAIR_LO) + SLOT_W'(SVC_BASE);
            default:   slot = idx_s;
        endcase
    end

endmodule

// File: rtl/bankreg_store.sv
// Flat physical storage of all base and shadow copies: one write port and
// RD_PORTS combinational read ports. Contents are not reset.
module bankreg_store #(
    parameter int DATA_W   = 32,
    parameter int SLOTS    = 26,
    parameter int SLOT_W   = 5,
    parameter int RD_PORTS = 2
) (
    input  logic                             clk,
    input  logic                             we,
    input  logic [SLOT_W-1:0]                wslot,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [RD_PORTS-1:0][SLOT_W-1:0]  rslot,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] mem_q [SLOTS];

    // Store the write data into the selected slot on the rising edge.
    always_ff @(posedge clk) begin
        if (we) mem_q[wslot] <= wdata;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        // Read the addressed slot without a register stage.
        always_comb rdata[p] = mem_q[rslot[p]];
    end

endmodule

// File: rtl/bankreg_pc.sv
// Program counter: synchronous active-low clear, load takes priority over step.
module bankreg_pc #(
    parameter int DATA_W  = 32,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] pc_q
);

    // Clear, load or advance the instruction address.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (load_en) pc_q <= load_val;
        else if (step_en) pc_q <= pc_q + DATA_W'(PC_STEP);
    end

endmodule

// File: rtl/bankreg_file.sv
// Mode-banked register file top. Sixteen architectural registers, with index
// 15 served by the program counter (reads return pc + PC_AHEAD). The mode
// chooses the shadow copy for each index. Assumes mode is stable within a cycle.
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PC_STEP  = 4,
    parameter int PC_AHEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pc_step_en,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] pc_q
);

    localparam int RD_PORTS = 2;

    logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx;
    logic [RD_PORTS-1:0][SLOT_W-1:0] rd_slot;
    logic [RD_PORTS-1:0][DATA_W-1:0] st_data;
    logic [RD_PORTS-1:0][DATA_W-1:0] rd_data;
    logic [SLOT_W-1:0]               wr_slot;
    logic                            st_we;
    logic                            pc_load;
    logic [DATA_W-1:0]               pc_ahead;

    // Gather the read indices and split the write between storage and pc.
    always_comb begin
        rd_idx[0] = rd_a_idx;
        rd_idx[1] = rd_b_idx;
        pc_load   = wr_en && (wr_idx == IDX_PC);
        st_we     = wr_en && (wr_idx != IDX_PC);
        pc_ahead  = pc_q + DATA_W'(PC_AHEAD);
    end

    bankreg_map u_wmap (
        .mode (mode),
        .idx  (wr_idx),
        .slot (wr_slot)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        bankreg_map u_rmap (
            .mode (mode),
            .idx  (rd_idx[p]),
            .slot (rd_slot[p])
        );
        // Substitute the look-ahead pc for index 15.
        always_comb rd_data[p] = (rd_idx[p] == IDX_PC) ? pc_ahead : st_data[p];
    end

    bankreg_store #(
        .DATA_W   (DATA_W),
        .SLOTS    (SLOT_CNT),
        .SLOT_W   (SLOT_W),
        .RD_PORTS (RD_PORTS)
    ) u_store (
        .clk   (clk),
        .we    (st_we),
        .wslot (wr_slot),
        .wdata (wr_data),
        .rslot (rd_slot),
        .rdata (st_data)
    );

    bankreg_pc #(
        .DATA_W  (DATA_W),
        .PC_STEP (PC_STEP)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (pc_step_en),
        .load_en  (pc_load),
        .load_val (wr_data),
        .pc_q     (pc_q)
    );

    // Present the port views.
    always_comb begin
        rd_a_data = rd_data[0];
        rd_b_data = rd_data[1];
    end

endmodule

// File: rtl/bankreg_file_chk.sv
// Port-level properties of the mode-banked register file, bound to the top.
module bankreg_file_chk
    import bankreg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PC_STEP  = 4,
    parameter int PC_AHEAD = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              pc_step_en,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic [DATA_W-1:0] pc_q
);

    a_r1_pc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_q == '0));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_step_en && !(wr_en && wr_idx == IDX_PC)) |=>
        (pc_q == $past(pc_q) + DATA_W'(PC_STEP)));

    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_step_en && !(wr_en && wr_idx == IDX_PC)) |=> $stable(pc_q));

    a_r3_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_PC) |=> (pc_q == $past(wr_data)));

    a_r4_pc_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == IDX_PC) |-> (rd_a_data == pc_q + DATA_W'(PC_AHEAD)));

    a_r4_pc_read_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == IDX_PC) |-> (rd_b_data == pc_q + DATA_W'(PC_AHEAD)));

    a_r10_write_visible_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_PC) |=>
        (rd_a_idx != $past(wr_idx) || mode != $past(mode) || rd_a_data == $past(wr_data)));

    a_r10_write_visible_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_PC) |=>
        (rd_b_idx != $past(wr_idx) || mode != $past(mode) || rd_b_data == $past(wr_data)));

endmodule

bind bankreg_file bankreg_file_chk #(
    .DATA_W   (DATA_W),
    .PC_STEP  (PC_STEP),
    .PC_AHEAD (PC_AHEAD)
) u_chk (.*);

// File: tb/bankreg_file_tb.sv
// Self-checking bench: sweeps every mode and index pair twice and exercises
// the program counter paths. Expected values come from a per-mode model.
module bankreg_file_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pc_step_en = 1'b0;
    logic [3:0]  rd_a_idx = 4'd0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = 4'd0;
    logic [31:0] rd_b_data;
    logic [31:0] pc_q;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q [4][15];

    bankreg_file u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .pc_step_en (pc_step_en),
        .rd_a_idx   (rd_a_idx),
        .rd_a_data  (rd_a_data),
        .rd_b_idx   (rd_b_idx),
        .rd_b_data  (rd_b_data),
        .pc_q       (pc_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Does this mode own a private copy of this index (R6, R7, R8)?
    function automatic bit owns_copy(int m, int i);
        return (m == 1 && i >= 8) || (m >= 2 && i >= 13);
    endfunction

    function automatic bit shares(int m1, int m2, int i);
        return (m1 == m2) || (!owns_copy(m1, i) && !owns_copy(m2, i));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Write one register in a mode and update every model view sharing that copy (R9).
    task automatic write_reg(int m, int i, logic [31:0] d);
        mode = 2'(m); wr_idx = 4'(i); wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        for (int m2 = 0; m2 < 4; m2++)
            if (shares(m, m2, i)) exp_q[m2][i] = d;
    endtask

    // Read every mode and index pair on both ports (R5-R8 per mode, R9 isolation).
    task automatic sweep_reads();
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 15; i++) begin
                string req;
                req = (m == 0) ? "R5" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R8";
                mode = 2'(m); rd_a_idx = 4'(i); rd_b_idx = 4'(14 - i);
                #1;
                check({req, "/R9 port A"}, rd_a_data, exp_q[m][i]);
                check({req, "/R10 port B"}, rd_b_data, exp_q[m][14 - i]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] prev;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1 reset pc", pc_q, 32'd0);
        rd_a_idx = 4'd15; rd_b_idx = 4'd15;
        #1;
        check("R4 port A pc+8", rd_a_data, 32'd8);
        check("R4 port B pc+8", rd_b_data, 32'd8);

        // Two full write sweeps in opposite mode orders with distinct data.
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 15; i++)
                write_reg(m, i, 32'hA000_0000 | (m << 16) | (i << 8) | 32'h11);
        sweep_reads();
        for (int m = 3; m >= 0; m--)
            for (int i = 14; i >= 0; i--)
                write_reg(m, i, 32'h5000_0000 | (m << 20) | (i << 4) | 32'h7);
        sweep_reads();

        // R9: fast-interrupt write to a banked index leaves the user copy alone.
        write_reg(1, 10, 32'hDEAD_0010);
        mode = 2'b00; rd_a_idx = 4'd10;
        #1;
        check("R9 user r10 after fast write", rd_a_data, exp_q[0][10]);
        mode = 2'b01;
        #1;
        check("R9 fast r10 kept", rd_a_data, 32'hDEAD_0010);
        // R6: fast-interrupt write to an unbanked index is seen by user mode.
        write_reg(1, 3, 32'hBEEF_0003);
        mode = 2'b00; rd_a_idx = 4'd3;
        #1;
        check("R6 shared r3 seen in user", rd_a_data, 32'hBEEF_0003);
        // R8 vs R7: supervisor stack pointer separate from normal-interrupt one.
        write_reg(3, 13, 32'h5555_0013);
        mode = 2'b10; rd_a_idx = 4'd13;
        #1;
        check("R7 irq r13 unchanged by svc write", rd_a_data, exp_q[2][13]);

        // R10: same-cycle read returns the old value, next cycle the new one.
        mode = 2'b00; rd_a_idx = 4'd5; rd_b_idx = 4'd6;
        wr_idx = 4'd5; wr_data = 32'h0F0F_0505; wr_en = 1'b1;
        #1;
        check("R10 old value in write cycle", rd_a_data, exp_q[0][5]);
        tick();
        wr_en = 1'b0;
        exp_q[0][5] = 32'h0F0F_0505;
        check("R10 new value after edge", rd_a_data, 32'h0F0F_0505);
        check("R10 port B independent", rd_b_data, exp_q[0][6]);

        // R2: step by 4, then hold.
        pc_step_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            prev = pc_q;
            tick();
            check("R2 pc step", pc_q, prev + 32'd4);
        end
        pc_step_en = 1'b0;
        prev = pc_q;
        tick(); tick();
        check("R2 pc hold", pc_q, prev);

        // R3: load overrides step; R4 follows the loaded value.
        pc_step_en = 1'b1;
        wr_idx = 4'd15; wr_data = 32'h0000_1000; wr_en = 1'b1; mode = 2'b01;
        tick();
        wr_en = 1'b0; pc_step_en = 1'b0;
        check("R3 pc load", pc_q, 32'h0000_1000);
        rd_a_idx = 4'd15; rd_b_idx = 4'd14;
        #1;
        check("R4 pc+8 after load", rd_a_data, 32'h0000_1008);
        check("R3 no side write", rd_b_data, exp_q[1][14]);

        // R2 wrap at the top of the address space.
        write_reg(0, 15, 32'hFFFF_FFFC);
        check("R3 pc load high", pc_q, 32'hFFFF_FFFC);
        pc_step_en = 1'b1;
        tick();
        pc_step_en = 1'b0;
        check("R2 pc wrap", pc_q, 32'd0);

        // R1 reset mid-run.
        pc_step_en = 1'b1;
        tick(); tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1; pc_step_en = 1'b0;
        check("R1 reset mid-run", pc_q, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule